// File: doc/BRIEF.md
# Instruction Fetch Address Mapper

This block turns a program counter into a physical fetch request. The counter counts 32-bit words, so the byte address is the counter shifted left by two. The fetch space is split into two halves by the top byte-address bit. Each half has its own 16-bit map register. A map register either sends its half directly to internal instruction memory, or names one numbered segment of unified memory that the half is fetched from.

Each cycle the block reports the memory target, the segment number, the byte offset and whether the fetch is valid. A unified segment is only usable when its bit in a presence mask input is set. A fetch to a segment whose bit is clear gives no valid fetch and sets a fault flag. The flag stays set until it is cleared explicitly. Software-side logic writes and reads the two map registers through a small register port. A write changes the mapping from the next cycle onward.

Top module: `ifm_fetch_mapper`

## Requirements
- R1: After reset, both map registers read back 0x1000 and the fault flag is 0.
- R2: The byte offset output equals the program counter shifted left by two bits.
- R3: When byte-address bit 17 is set, the mapping comes from map register 1. When it is clear, the mapping comes from map register 0.
- R4: When bit 12 of the selected map is 1, the target output is 0 (instruction memory), the segment output is 0 and a requested fetch is valid.
- R5: When bit 12 of the selected map is 0, the target output is 1 (unified memory) and the segment output equals bits 7:0 of the map. All other map bits are ignored.
- R6: A requested fetch to a unified segment whose presence bit is clear has fetch_valid low. The fault flag reads 1 from the cycle after it.
- R7: The fault flag stays set until fault_clr is asserted in a cycle with no new fault. A new fault in the same cycle as fault_clr keeps the flag set.
- R8: A map write takes effect at the clock edge where map_we is high. Readback and fetch outputs show the new value from then on, and never before that edge.
- R9: With fetch_req low, fetch_valid is low and the fault flag does not change, even for an unmapped segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | A fetch is requested this cycle |
| pc_word | input | 16 | Program counter as a word index |
| seg_present | input | 256 | One bit per unified segment; 1 means mapped |
| map_we | input | 1 | Write enable for the map registers |
| map_wsel | input | 1 | Map register to write (0 or 1) |
| map_wdata | input | 16 | Write data |
| map_rsel | input | 1 | Map register to read back |
| map_rdata | output | 16 | Readback of the selected map register |
| fault_clr | input | 1 | Clears the sticky fault flag |
| fetch_valid | output | 1 | The requested fetch has a valid target |
| fetch_tgt | output | 1 | 0 = instruction memory, 1 = unified memory |
| fetch_seg | output | 8 | Unified segment number (0 for instruction memory) |
| fetch_addr | output | 18 | Physical byte offset |
| fault | output | 1 | Sticky fetch-fault flag |

## Verification
The bench builds the block with its default parameters: an 18-bit byte space, two 16-bit maps and a 256-entry presence mask. These values let it reach the bank-select bit with counter bit 15, and the segment extremes 0 and 255 of an 8-bit segment field. The bench also writes map values where bits outside 12 and 7:0 are set, which shows that those bits have no effect. It probes the outputs just before and just after a write edge, and also around cycles where fault set and fault clear collide.

// File: rtl/ifm_pkg.sv
package ifm_pkg;

    typedef enum logic {
        TGT_IMEM = 1'b0,
        TGT_UMEM = 1'b1
    } fetch_tgt_e;

    localparam logic [15:0] MAP_RESET_VAL = 16'h1000;

    // Byte address from a word index.
    function automatic logic [31:0] word_to_byte(input logic [31:0] w);
        return w << 2;
    endfunction

endpackage

// File: rtl/ifm_map_regs.sv
module ifm_map_regs #(
    parameter int          NUM_MAPS  = 2,
    parameter int          MAP_W     = 16,
    parameter logic [15:0] RESET_VAL = 16'h1000,
    localparam int         SEL_W     = (NUM_MAPS > 1) ? $clog2(NUM_MAPS) : 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we,
    input  logic [SEL_W-1:0]               wsel,
    input  logic [MAP_W-1:0]               wdata,
    input  logic [SEL_W-1:0]               rsel,
    output logic [MAP_W-1:0]               rdata,
    output logic [NUM_MAPS-1:0][MAP_W-1:0] maps
);

    for (genvar g = 0; g < NUM_MAPS; g++) begin : g_map
        always_ff @(posedge clk) begin
            if (rst)
                maps[g] <= MAP_W'(RESET_VAL);
            else if (we && (wsel == SEL_W'(g)))
                maps[g] <= wdata;
        end
    end

    assign rdata = maps[rsel];

endmodule

// File: rtl/ifm_route.sv
module ifm_route
    import ifm_pkg::*;
#(
    parameter int  PC_W       = 16,
    parameter int  MAP_W      = 16,
    parameter int  DIRECT_BIT = 12,
    parameter int  SEG_W      = 8,
    localparam int ADDR_W     = PC_W + 2,
    localparam int NUM_SEG    = 1 << SEG_W
) (
    input  logic                    req,
    input  logic [PC_W-1:0]         pc,
    input  logic [1:0][MAP_W-1:0]   maps,
    input  logic [NUM_SEG-1:0]      present,
    output logic                    valid,
    output fetch_tgt_e              tgt,
    output logic [SEG_W-1:0]        seg,
    output logic [ADDR_W-1:0]       addr,
    output logic                    miss
);

    logic [31:0]      byte_full;
    logic             bank;
    logic [MAP_W-1:0] cur_map;
    logic             direct;
    logic [SEG_W-1:0] map_seg;
    logic             seg_ok;
    logic             unused_bits;

    assign byte_full   = word_to_byte(32'(pc));
    assign addr        = byte_full[ADDR_W-1:0];
    assign unused_bits = ^byte_full[31:ADDR_W] ^ ^cur_map;
    assign bank        = addr[ADDR_W-1];
    assign cur_map     = maps[bank];
    assign direct      = cur_map[DIRECT_BIT];
    assign map_seg     = cur_map[SEG_W-1:0];
    assign seg_ok      = present[map_seg];

    always_comb begin
        if (direct) begin
            tgt = TGT_IMEM;
            seg = '0;
        end else begin
            tgt = TGT_UMEM;
            seg = map_seg;
        end
        valid = req && (direct || seg_ok);
        miss  = req && !direct && !seg_ok;
    end

endmodule

// File: rtl/ifm_fault_latch.sv
module ifm_fault_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set_i)
            flag <= 1'b1;
        else if (clr_i)
            flag <= 1'b0;
    end

endmodule

// File: rtl/ifm_fetch_mapper.sv
module ifm_fetch_mapper
    import ifm_pkg::*;
#(
    parameter int  PC_W       = 16,
    parameter int  MAP_W      = 16,
    parameter int  DIRECT_BIT = 12,
    parameter int  SEG_W      = 8,
    localparam int ADDR_W     = PC_W + 2,
    localparam int NUM_SEG    = 1 << SEG_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fetch_req,
    input  logic [PC_W-1:0]    pc_word,
    input  logic [NUM_SEG-1:0] seg_present,
    input  logic               map_we,
    input  logic               map_wsel,
    input  logic [MAP_W-1:0]   map_wdata,
    input  logic               map_rsel,
    output logic [MAP_W-1:0]   map_rdata,
    input  logic               fault_clr,
    output logic               fetch_valid,
    output logic               fetch_tgt,
    output logic [SEG_W-1:0]   fetch_seg,
    output logic [ADDR_W-1:0]  fetch_addr,
    output logic               fault
);

    logic [1:0][MAP_W-1:0] maps;
    fetch_tgt_e            tgt_e;
    logic                  miss;

    ifm_map_regs #(
        .NUM_MAPS (2),
        .MAP_W    (MAP_W),
        .RESET_VAL(MAP_RESET_VAL)
    ) u_regs (
        .clk  (clk),
        .rst  (rst),
        .we   (map_we),
        .wsel (map_wsel),
        .wdata(map_wdata),
        .rsel (map_rsel),
        .rdata(map_rdata),
        .maps (maps)
    );

    ifm_route #(
        .PC_W      (PC_W),
        .MAP_W     (MAP_W),
        .DIRECT_BIT(DIRECT_BIT),
        .SEG_W     (SEG_W)
    ) u_route (
        .req    (fetch_req),
        .pc     (pc_word),
        .maps   (maps),
        .present(seg_present),
        .valid  (fetch_valid),
        .tgt    (tgt_e),
        .seg    (fetch_seg),
        .addr   (fetch_addr),
        .miss   (miss)
    );

    ifm_fault_latch u_fault (
        .clk  (clk),
        .rst  (rst),
        .set_i(miss),
        .clr_i(fault_clr),
        .flag (fault)
    );

    assign fetch_tgt = tgt_e;

endmodule

// File: rtl/ifm_fetch_mapper_chk.sv
module ifm_fetch_mapper_chk #(
    parameter int MAP_W = 16,
    parameter int SEG_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             fetch_req,
    input logic             fetch_valid,
    input logic             fetch_tgt,
    input logic [SEG_W-1:0] fetch_seg,
    input logic             fault_clr,
    input logic             fault,
    input logic             map_we,
    input logic             map_wsel,
    input logic [MAP_W-1:0] map_wdata,
    input logic             map_rsel,
    input logic [MAP_W-1:0] map_rdata
);

    // R6
    miss_sets_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !fetch_valid) |=> fault);

    // R7
    fault_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (fault && !fault_clr) |=> fault);

    // R7
    fault_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (fault_clr && !(fetch_req && !fetch_valid)) |=> !fault);

    // R4
    imem_seg_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && !fetch_tgt) |-> (fetch_seg == '0));

    // R9
    no_req_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !fetch_req |-> !fetch_valid);

    // R9
    no_req_fault_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!fetch_req && !fault_clr) |=> $stable(fault));

    // R8
    write_readback_chk: assert property (@(posedge clk) disable iff (rst)
        (map_we && (map_rsel == map_wsel)) |=> (map_rdata == $past(map_wdata)) || (map_rsel != $past(map_wsel)));

endmodule

bind ifm_fetch_mapper ifm_fetch_mapper_chk #(
    .MAP_W(MAP_W),
    .SEG_W(SEG_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fetch_req  (fetch_req),
    .fetch_valid(fetch_valid),
    .fetch_tgt  (fetch_tgt),
    .fetch_seg  (fetch_seg),
    .fault_clr  (fault_clr),
    .fault      (fault),
    .map_we     (map_we),
    .map_wsel   (map_wsel),
    .map_wdata  (map_wdata),
    .map_rsel   (map_rsel),
    .map_rdata  (map_rdata)
);

// File: tb/ifm_fetch_mapper_tb_top.sv
module ifm_fetch_mapper_tb_top;

    logic         clk = 1'b0;
    logic         rst;
    logic         fetch_req;
    logic [15:0]  pc_word;
    logic [255:0] seg_present;
    logic         map_we;
    logic         map_wsel;
    logic [15:0]  map_wdata;
    logic         map_rsel;
    logic [15:0]  map_rdata;
    logic         fault_clr;
    logic         fetch_valid;
    logic         fetch_tgt;
    logic [7:0]   fetch_seg;
    logic [17:0]  fetch_addr;
    logic         fault;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ifm_fetch_mapper dut_i (
        .clk        (clk),
        .rst        (rst),
        .fetch_req  (fetch_req),
        .pc_word    (pc_word),
        .seg_present(seg_present),
        .map_we     (map_we),
        .map_wsel   (map_wsel),
        .map_wdata  (map_wdata),
        .map_rsel   (map_rsel),
        .map_rdata  (map_rdata),
        .fault_clr  (fault_clr),
        .fetch_valid(fetch_valid),
        .fetch_tgt  (fetch_tgt),
        .fetch_seg  (fetch_seg),
        .fetch_addr (fetch_addr),
        .fault      (fault)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic ck(input string req, input logic [31:0] act, input logic [31:0] exp);
        check(act == exp, req, act, exp);
    endtask

    // Advance to the next falling edge; inputs change and outputs are sampled there.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_map(input logic sel, input logic [15:0] val);
        map_we    = 1'b1;
        map_wsel  = sel;
        map_wdata = val;
        step();
        map_we    = 1'b0;
    endtask

    task automatic t_reset();
        map_rsel = 1'b0;
        #1 ck("R1 map0 reset", 32'(map_rdata), 32'h1000);
        map_rsel = 1'b1;
        #1 ck("R1 map1 reset", 32'(map_rdata), 32'h1000);
        ck("R1 fault reset", 32'(fault), 0);
    endtask

    task automatic t_imem();
        fetch_req = 1'b1;
        pc_word   = 16'h0123;
        #1;
        ck("R2 byte addr low", 32'(fetch_addr), 32'h0048C);
        ck("R4 tgt imem", 32'(fetch_tgt), 0);
        ck("R4 seg zero", 32'(fetch_seg), 0);
        ck("R4 valid", 32'(fetch_valid), 1);
        pc_word = 16'h8001;
        #1;
        ck("R2 byte addr high", 32'(fetch_addr), 32'h20004);
        ck("R4 high half imem", 32'(fetch_tgt), 0);
        step();
        ck("R4 no fault", 32'(fault), 0);
    endtask

    task automatic t_unified();
        seg_present    = '0;
        seg_present[3] = 1'b1;
        write_map(1'b1, 16'hE003);   // bit12 clear, other high bits set
        pc_word = 16'h8002;
        #1;
        ck("R5 tgt unified", 32'(fetch_tgt), 1);
        ck("R5 seg from low byte", 32'(fetch_seg), 3);
        ck("R5 offset", 32'(fetch_addr), 32'h20008);
        ck("R5 valid", 32'(fetch_valid), 1);
        pc_word = 16'h0002;
        #1;
        ck("R3 low half uses map0", 32'(fetch_tgt), 0);
        write_map(1'b1, 16'h1F05);   // bit12 set wins over segment bits
        pc_word = 16'hFFFF;
        #1;
        ck("R3 high half uses map1", 32'(fetch_tgt), 0);
        ck("R4 seg zero with bits", 32'(fetch_seg), 0);
        ck("R2 top addr", 32'(fetch_addr), 32'h3FFFC);
    endtask

    task automatic t_write_timing();
        seg_present      = '0;
        seg_present[255] = 1'b1;
        pc_word   = 16'h0010;
        map_we    = 1'b1;
        map_wsel  = 1'b0;
        map_wdata = 16'h00FF;
        map_rsel  = 1'b0;
        #1;
        ck("R8 old map before edge", 32'(fetch_tgt), 0);
        ck("R8 old readback", 32'(map_rdata), 32'h1000);
        step();
        map_we = 1'b0;
        #1;
        ck("R8 new readback", 32'(map_rdata), 32'h00FF);
        ck("R8 new tgt", 32'(fetch_tgt), 1);
        ck("R5 seg 255", 32'(fetch_seg), 255);
        ck("R8 valid", 32'(fetch_valid), 1);
    endtask

    task automatic t_fault();
        write_map(1'b0, 16'h0000);   // segment 0, not present
        seg_present = '0;
        fetch_req   = 1'b1;
        pc_word     = 16'h0004;
        #1;
        ck("R6 invalid", 32'(fetch_valid), 0);
        ck("R6 not yet set", 32'(fault), 0);
        step();
        ck("R6 set", 32'(fault), 1);
        fetch_req = 1'b0;
        step();
        step();
        ck("R7 sticky", 32'(fault), 1);
        fault_clr = 1'b1;
        step();
        fault_clr = 1'b0;
        ck("R7 cleared", 32'(fault), 0);
        fetch_req = 1'b1;
        fault_clr = 1'b1;
        step();
        fault_clr = 1'b0;
        fetch_req = 1'b0;
        ck("R7 set beats clear", 32'(fault), 1);
        fault_clr = 1'b1;
        step();
        fault_clr = 1'b0;
        ck("R7 cleared again", 32'(fault), 0);
        seg_present[0] = 1'b1;
        fetch_req = 1'b1;
        #1 ck("R6 present now valid", 32'(fetch_valid), 1);
        step();
        ck("R6 no fault when present", 32'(fault), 0);
    endtask

    task automatic t_noreq();
        seg_present = '0;
        fetch_req   = 1'b0;
        pc_word     = 16'h0004;
        #1 ck("R9 valid low", 32'(fetch_valid), 0);
        step();
        step();
        ck("R9 no fault", 32'(fault), 0);
    endtask

    initial begin
        rst = 1'b1; fetch_req = 1'b0; pc_word = '0; seg_present = '0;
        map_we = 1'b0; map_wsel = 1'b0; map_wdata = '0; map_rsel = 1'b0;
        fault_clr = 1'b0;
        step();
        step();
        rst = 1'b0;
        t_reset();
        t_imem();
        t_unified();
        t_write_timing();
        t_fault();
        t_noreq();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule